// File: doc/BRIEF.md
# Lockstep Output Comparison Controller

This block watches a main processor core and a redundant copy of it that runs a fixed number of cycles behind. Both cores present a wide output bus. The redundant core is fed its inputs through two register stages, so its bus shows a given result two cycles after the main core's bus does. The controller delays each bus by a different number of register stages so that matching results meet at the same clock edge. It then compares them in two separate comparator copies. Each copy owns a sticky fault flag and an active-low clear input. Downstream logic treats a raised flag on either copy as a failure.

A qualification sequencer holds both comparators off while the alignment registers still hold reset contents after power-on reset. It has two states. HOLD is entered on power-on reset and counts clock edges. Its transition ARM fires when the hold count is used up, and the sequencer moves to ARMED. ARMED is left only through power-on reset. Each comparator copy also has two states. CLEAR is the reset state. Its transition TRIP moves to LATCHED on a qualified mismatch. LATCHED returns to CLEAR through the transition RELEASE, which needs the clear input low and no qualified mismatch in that cycle. A verification-only inversion path can flip selected redundant bits before alignment, which lets a test create a mismatch on demand.

Top module: `lockstep_cmp_ctrl`

## Requirements
- R1: While `por_n` is low, both fault flags are 0 and every register in the block is cleared. A power-on reset in mid-run drops a raised flag to 0.
- R2: With the default lag of 2, the main bus passes through 3 register stages and the redundant bus through 1. When the redundant bus always equals the main bus from two cycles earlier, neither flag ever rises.
- R3: Number the rising clock edges from 1, starting with the first edge after `por_n` rises. Suppose the main bus sampled at edge n differs from the redundant bus sampled at edge n+2, with n at least 1. Then both flags are 1 after edge n+3.
- R4: Comparison results are ignored at edges 1 to 3 after power-on reset. A difference that reaches the comparators only in that window sets no flag.
- R5: A raised flag stays 1 for as long as its clear input stays high.
- R6: Driving `clr_a_n` low for one cycle with no qualified mismatch clears `fault_a` after that edge. `fault_b` is unaffected.
- R7: Driving `clr_b_n` low for one cycle with no qualified mismatch clears `fault_b` after that edge. `fault_a` is unaffected.
- R8: A qualified mismatch at the same edge where a clear input is low leaves that flag at 1.
- R9: When `inj_en` is 1, every redundant bit whose `inj_mask` bit is 1 is inverted before alignment, and this shows up as a mismatch. When `inj_en` is 0, `inj_mask` has no effect.
- R10: The bus width is set by `WIDTH`. Every bit position from 0 to `WIDTH`-1 takes part in the comparison, and bits above `WIDTH`-1 do not exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single shared clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| main_out | input | WIDTH | Output bus of the main core |
| red_out | input | WIDTH | Output bus of the redundant core, two cycles late |
| inj_en | input | 1 | Enables fault injection on the redundant bus |
| inj_mask | input | WIDTH | Per-bit inversion select for fault injection |
| clr_a_n | input | 1 | Active-low clear of comparator copy A's flag |
| clr_b_n | input | 1 | Active-low clear of comparator copy B's flag |
| fault_a | output | 1 | Sticky fault flag of comparator copy A |
| fault_b | output | 1 | Sticky fault flag of comparator copy B |

## Verification
The bench builds the block twice from the same stimulus. One copy is 8 bits wide and the other 1024 bits wide. The narrow copy gets the low byte of each bus. Single-bit flips and single-bit injections are swept over positions 0 to 15 in both copies. Flips in positions 8 to 15 must trip only the wide copy. Flips at the top positions of the 1024-bit copy check that the full bus width takes part in the comparison. The expected flag values come from the lag arithmetic of the requirements, applied to the bench's own record of what it drove.

// File: rtl/lsc_pkg.sv
`timescale 1ns/1ps
package lsc_pkg;
    typedef enum logic {QS_HOLD, QS_ARMED} qual_state_e;
    typedef enum logic {FS_CLEAR, FS_LATCHED} flag_state_e;
endpackage

// File: rtl/lsc_delay.sv
`timescale 1ns/1ps
module lsc_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        logic [WIDTH-1:0] q;
        if (s == 0) begin : g_head
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) q <= '0;
                else        q <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) q <= '0;
                else        q <= g_stage[s-1].q;
            end
        end
    end

    assign dout = g_stage[DEPTH-1].q;
endmodule

// File: rtl/lsc_qual.sv
`timescale 1ns/1ps
module lsc_qual
    import lsc_pkg::*;
#(
    parameter int HOLD_CYCLES = 3
) (
    input  logic clk,
    input  logic por_n,
    output logic armed
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    qual_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QS_HOLD: begin
                if (cnt_q == LAST) state_d = QS_ARMED;   // ARM
                else               cnt_d   = cnt_q + 1'b1;
            end
            QS_ARMED: begin
                state_d = QS_ARMED;
            end
            default: state_d = QS_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= QS_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb armed = (state_q == QS_ARMED);

    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        armed |=> armed);                                              // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        !armed |-> (cnt_q < CW'(HOLD_CYCLES)));                        // R4
endmodule

// File: rtl/lsc_cmp.sv
`timescale 1ns/1ps
module lsc_cmp
    import lsc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             en,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    output logic             fault
);
    flag_state_e state_q, state_d;
    logic        trip;

    always_comb trip = en && (|(lhs ^ rhs));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_CLEAR:   if (trip) state_d = FS_LATCHED;             // TRIP
            FS_LATCHED: if (!trip && !clr_n) state_d = FS_CLEAR;    // RELEASE
            default:    state_d = FS_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= FS_CLEAR;
        else        state_q <= state_d;
    end

    always_comb fault = (state_q == FS_LATCHED);

    AST_SET_ON_DIFF: assert property (@(posedge clk) disable iff (!por_n)
        (en && (lhs != rhs)) |=> fault);                               // R3
    AST_QUIET_UNQUAL: assert property (@(posedge clk) disable iff (!por_n)
        (!en && !fault) |=> !fault);                                   // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (fault && clr_n) |=> fault);                                   // R5
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (!por_n)
        (!clr_n && !(en && (lhs != rhs))) |=> !fault);                 // R6
endmodule

// File: rtl/lockstep_cmp_ctrl.sv
`timescale 1ns/1ps
module lockstep_cmp_ctrl #(
    parameter int WIDTH      = 64,
    parameter int RED_LAG    = 2,
    parameter int RED_STAGES = 1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] main_out,
    input  logic [WIDTH-1:0] red_out,
    input  logic             inj_en,
    input  logic [WIDTH-1:0] inj_mask,
    input  logic             clr_a_n,
    input  logic             clr_b_n,
    output logic             fault_a,
    output logic             fault_b
);
    localparam int MAIN_STAGES = RED_LAG + RED_STAGES;
    localparam int QUAL_CYCLES = MAIN_STAGES;
    localparam int N_COPIES    = 2;

    logic [WIDTH-1:0]    red_mod;
    logic [WIDTH-1:0]    main_al;
    logic [WIDTH-1:0]    red_al;
    logic                armed;
    logic [N_COPIES-1:0] clr_vec;
    logic [N_COPIES-1:0] fault_vec;

    always_comb red_mod = inj_en ? (red_out ^ inj_mask) : red_out;

    lsc_delay #(.WIDTH(WIDTH), .DEPTH(MAIN_STAGES)) u_main_dly (
        .clk(clk), .por_n(por_n), .din(main_out), .dout(main_al));

    lsc_delay #(.WIDTH(WIDTH), .DEPTH(RED_STAGES)) u_red_dly (
        .clk(clk), .por_n(por_n), .din(red_mod), .dout(red_al));

    lsc_qual #(.HOLD_CYCLES(QUAL_CYCLES)) u_qual (
        .clk(clk), .por_n(por_n), .armed(armed));

    assign clr_vec = {clr_b_n, clr_a_n};

    for (genvar c = 0; c < N_COPIES; c++) begin : g_copy
        lsc_cmp #(.WIDTH(WIDTH)) u_cmp (
            .clk   (clk),
            .por_n (por_n),
            .en    (armed),
            .clr_n (clr_vec[c]),
            .lhs   (main_al),
            .rhs   (red_al),
            .fault (fault_vec[c])
        );
    end

    assign fault_a = fault_vec[0];
    assign fault_b = fault_vec[1];

    AST_PAIR_SET: assert property (@(posedge clk) disable iff (!por_n)
        (armed && (main_al != red_al)) |=> (fault_a && fault_b));      // R3
    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (!fault_a && !fault_b && (main_al == red_al)) |=> (!fault_a && !fault_b)); // R2
endmodule

// File: tb/lockstep_cmp_ctrl_tb_top.sv
`timescale 1ns/1ps
module lockstep_cmp_ctrl_tb_top;
    localparam int WW   = 1024;
    localparam int NW   = 8;
    localparam int MAXK = 4095;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          por_n;
    logic [WW-1:0] main_v, red_v, mask_v;
    logic          inj_v, ca_v, cb_v;
    logic          fa_n, fb_n, fa_w, fb_w;

    lockstep_cmp_ctrl #(.WIDTH(NW)) dut_i (
        .clk(clk), .por_n(por_n), .main_out(main_v[NW-1:0]), .red_out(red_v[NW-1:0]),
        .inj_en(inj_v), .inj_mask(mask_v[NW-1:0]), .clr_a_n(ca_v), .clr_b_n(cb_v),
        .fault_a(fa_n), .fault_b(fb_n));

    lockstep_cmp_ctrl #(.WIDTH(WW)) dut_wide_i (
        .clk(clk), .por_n(por_n), .main_out(main_v), .red_out(red_v),
        .inj_en(inj_v), .inj_mask(mask_v), .clr_a_n(ca_v), .clr_b_n(cb_v),
        .fault_a(fa_w), .fault_b(fb_w));

    logic [WW-1:0] mh [0:MAXK];
    logic [WW-1:0] rh [0:MAXK];
    int    k;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    string req   = "R1";
    logic  exp_na, exp_nb, exp_wa, exp_wb;

    localparam logic [WW-1:0] ONE  = {{(WW-1){1'b0}}, 1'b1};
    localparam logic [WW-1:0] ZERO = '0;

    function automatic logic [WW-1:0] pat(int n);
        logic [WW-1:0] v;
        for (int i = 0; i < WW/32; i++)
            v[i*32 +: 32] = (32'(n) * 32'h9E3779B1) ^ (32'(i) * 32'h85EBCA6B);
        return v;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b (edge %0d)", req, tag, act, exp, k);
        end
    endtask

    task automatic check_all();
        chk("narrow fault_a", fa_n, exp_na);
        chk("narrow fault_b", fb_n, exp_nb);
        chk("wide fault_a",   fa_w, exp_wa);
        chk("wide fault_b",   fb_w, exp_wb);
    endtask

    // Called at a falling edge; drives the inputs for edge k+1. The redundant
    // bus repeats the main bus of two edges earlier, XORed with flip.
    task automatic step(input logic [WW-1:0] flip, input logic inj,
                        input logic [WW-1:0] mask, input logic ca, input logic cb);
        logic [WW-1:0] d;
        logic misn, misw;
        main_v = pat(k + 1 + 7919 * total);
        red_v  = (k >= 2) ? (mh[k-1] ^ flip) : flip;
        inj_v  = inj;
        mask_v = mask;
        ca_v   = ca;
        cb_v   = cb;
        @(posedge clk);
        k++;
        mh[k] = main_v;
        rh[k] = inj ? (red_v ^ mask) : red_v;
        misn = 1'b0;
        misw = 1'b0;
        if (k >= 4) begin            // R4: edges 1..3 are unqualified
            d    = mh[k-3] ^ rh[k-1];  // R2/R3: main at n vs redundant at n+2
            misw = |d;
            misn = |d[NW-1:0];
        end
        exp_na = misn ? 1'b1 : (!ca ? 1'b0 : exp_na);  // R8 set wins
        exp_nb = misn ? 1'b1 : (!cb ? 1'b0 : exp_nb);
        exp_wa = misw ? 1'b1 : (!ca ? 1'b0 : exp_wa);
        exp_wb = misw ? 1'b1 : (!cb ? 1'b0 : exp_wb);
        @(negedge clk);
        check_all();
    endtask

    task automatic clean(int n);
        for (int i = 0; i < n; i++) step(ZERO, 1'b0, ZERO, 1'b1, 1'b1);
    endtask

    task automatic por_cycle();
        req    = "R1";
        por_n  = 1'b0;
        k      = 0;
        main_v = '0; red_v = '0; mask_v = '0;
        inj_v  = 1'b0; ca_v = 1'b1; cb_v = 1'b1;
        exp_na = 1'b0; exp_nb = 1'b0; exp_wa = 1'b0; exp_wb = 1'b0;
        repeat (2) @(negedge clk);
        check_all();                 // R1 flags low under reset
        por_n = 1'b1;
    endtask

    initial begin
        por_n = 1'b0;
        k = 0;
        main_v = '0; red_v = '0; mask_v = '0;
        inj_v = 1'b0; ca_v = 1'b1; cb_v = 1'b1;
        exp_na = 1'b0; exp_nb = 1'b0; exp_wa = 1'b0; exp_wb = 1'b0;
        @(negedge clk);
        por_cycle();

        // R4: differences inside the qualification window are ignored
        req = "R4";
        step(~ZERO, 1'b0, ZERO, 1'b1, 1'b1);
        step(~ZERO, 1'b0, ZERO, 1'b1, 1'b1);
        clean(6);

        // R2: correctly lagged streams never trip
        req = "R2";
        clean(40);

        // R3/R10/R5/R6/R7: single-bit flip sweep across both widths
        for (int b = 0; b < 16; b++) begin
            req = (b < NW) ? "R3" : "R10";
            step(ONE << b, 1'b0, ZERO, 1'b1, 1'b1);
            req = "R5";
            clean(4);
            req = "R6_R7";
            step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);
            clean(1);
        end

        // R10: top bits of the wide bus
        req = "R10";
        step(ONE << (WW-1), 1'b0, ZERO, 1'b1, 1'b1);
        clean(2);
        step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);
        step(ONE << 511, 1'b0, ZERO, 1'b1, 1'b1);
        clean(2);
        step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);

        // R6: clear copy A only
        req = "R6";
        step(ONE, 1'b0, ZERO, 1'b1, 1'b1);
        clean(2);
        step(ZERO, 1'b0, ZERO, 1'b0, 1'b1);
        clean(2);
        // R7: clear copy B only
        req = "R7";
        step(ZERO, 1'b0, ZERO, 1'b1, 1'b0);
        clean(2);

        // R8: mismatch and clear at the same edge
        req = "R8";
        step(ONE << 2, 1'b0, ZERO, 1'b1, 1'b1);
        step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);
        clean(2);
        step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);
        clean(1);

        // R9: injection sweep, then mask with injection disabled
        for (int b = 0; b < 16; b++) begin
            req = "R9";
            step(ZERO, 1'b1, ONE << b, 1'b1, 1'b1);
            clean(2);
            step(ZERO, 1'b0, ZERO, 1'b0, 1'b0);
            clean(1);
        end
        req = "R9";
        for (int i = 0; i < 10; i++) step(ZERO, 1'b0, ~ZERO, 1'b1, 1'b1);

        // R1: power-on reset in mid-run clears raised flags
        req = "R1";
        step(ONE, 1'b0, ZERO, 1'b1, 1'b1);
        clean(2);
        @(negedge clk);
        por_cycle();
        req = "R1";
        clean(8);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule